// File: doc/BRIEF.md
# Complementary PWM Output Pair with Dead-Time Insertion

This block turns one PWM reference into a main output and its complementary output for a half-bridge. Each edge of the reference turns the outgoing output off at once. The incoming output turns on only after a programmable dead-time, so the two switches are never driven together. The dead-time is counted in ticks of a dead-time clock enable. An 8-bit code sets its length through a four-range piecewise scale: the short range is fine-grained and the longer ranges are coarse.

A main-enable flag decides whether the pair follows the reference. A pulse on `moeSet` sets the flag. A qualified break input clears it at once, without waiting for a clock edge. Two frozen-state bits decide how the pins behave when the pair is not following the reference:
- For a stopped timer with the main enable set, the outputs are either released or held enabled at the inactive (low) level.
- With the main enable clear, the outputs are either released or held enabled at per-pin idle levels.

A released pin has its enable low and its level low.

Top module: `dtPairStage`

## Requirements
- R1: After reset the main enable is clear and, with `frzRunOff`=0, all four outputs (`pinMain`, `pinMainEn`, `pinComp`, `pinCompEn`) are 0.
- R2: For code bit 7 = 0, the dead-time is the code value (0..127) in ticks.
- R3: For code bits 7:6 = 2'b10, the dead-time is (64 + code[5:0]) × 2 ticks.
- R4: For code bits 7:5 = 3'b110, the dead-time is (32 + code[4:0]) × 8 ticks.
- R5: For code bits 7:5 = 3'b111, the dead-time is (32 + code[4:0]) × 16 ticks.
- R6: The reference is registered once. With the main enable set and `timerRun`=1, the output turning off goes low one clock after the reference change, and the output turning on rises only once the dead-time has counted down. The two outputs are never high together, and both enables are 1.
- R7: A reference pulse shorter than the dead-time leaves the output that would have turned on low for the whole pulse.
- R8: With `timerRun`=0 and the main enable set, `frzRunOn`=0 drives all four outputs to 0. `frzRunOn`=1 sets both enables to 1 and both levels to 0.
- R9: With the main enable clear, `frzRunOff`=0 drives all four outputs to 0. `frzRunOff`=1 sets both enables to 1 and drives `pinMain`=`idleMain` and `pinComp`=`idleComp`.
- R10: With `brkEnable`=1 and `brkIn` equal to `brkPolarity`, the main enable clears with no clock edge needed. While that condition holds, `moeSet` has no effect.
- R11: With `brkEnable`=0, `brkIn` has no effect on the main enable or on the outputs.
- R12: A `moeSet` pulse with no active break sets the main enable at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dtTick | input | 1 | Dead-time clock enable; one count per clock with it high |
| pwmRef | input | 1 | PWM reference |
| dtCode | input | 8 | Dead-time code |
| timerRun | input | 1 | High while the timer is running |
| moeSet | input | 1 | Pulse that sets the main enable |
| brkIn | input | 1 | Break input |
| brkEnable | input | 1 | Break input qualifier |
| brkPolarity | input | 1 | Level of `brkIn` that counts as a break |
| frzRunOn | input | 1 | Frozen state for a stopped timer with the main enable set |
| frzRunOff | input | 1 | Frozen state with the main enable clear |
| idleMain | input | 1 | Idle level of the main output |
| idleComp | input | 1 | Idle level of the complementary output |
| pinMain | output | 1 | Main output level |
| pinMainEn | output | 1 | Main output enable |
| pinComp | output | 1 | Complementary output level |
| pinCompEn | output | 1 | Complementary output enable |

## Verification
The hardest situations to reach are the top of the longest code range, 1008 ticks, and the asynchronous clear of the main enable in the middle of a clock period. For each range, the bench lets the counter settle and then counts the clock periods in which both outputs are low around each reference edge. It repeats this with a tick at half rate. It raises the break between edges and samples the enables before the next rising edge arrives. It then mixes seeded random frozen-state, idle-level and enable settings with a stable reference, and compares the pins against a model of the output selection.

// File: rtl/dtPairPkg.sv
package dtPairPkg;
  localparam int CODE_W = 8;
  // longest dead-time is 63*16 = 1008 ticks
  localparam int LEN_W = 10;

  typedef struct packed {
    logic loadDt;   // reference edge: restart the dead-time
    logic stepDt;   // one dead-time tick
  } dtStrobe_t;
endpackage

// File: rtl/dtPairDatapath.sv
module dtPairDatapath
  import dtPairPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dtStrobe_t         strobe,
  input  logic [CODE_W-1:0] dtCode,
  output logic              dtDone
);
  logic [LEN_W-1:0] dtLen;
  logic [LEN_W-1:0] cnt;

  // piecewise decode of the dead-time code
  always_comb begin
    if (!dtCode[7])
      dtLen = LEN_W'(dtCode);
    else if (!dtCode[6])
      dtLen = (LEN_W'(dtCode[5:0]) + LEN_W'(64)) << 1;
    else if (!dtCode[5])
      dtLen = (LEN_W'(dtCode[4:0]) + LEN_W'(32)) << 3;
    else
      dtLen = (LEN_W'(dtCode[4:0]) + LEN_W'(32)) << 4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strobe.loadDt)
      cnt <= dtLen;
    else if (strobe.stepDt && cnt != '0)
      cnt <= cnt - LEN_W'(1);
  end

  assign dtDone = (cnt == '0);

  // R2: a non-zero load keeps the turn-on held back in the next cycle
  p_hold_after_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDt && dtLen != '0 |=> !dtDone);

  // R7: an expired count stays expired until the next edge
  p_done_stays_r7: assert property (@(posedge clk) disable iff (!rstN)
    dtDone && !strobe.loadDt |=> dtDone);
endmodule

// File: rtl/dtPairControl.sv
module dtPairControl
  import dtPairPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dtTick,
  input  logic      pwmRef,
  input  logic      timerRun,
  input  logic      moeSet,
  input  logic      brkIn,
  input  logic      brkEnable,
  input  logic      brkPolarity,
  input  logic      frzRunOn,
  input  logic      frzRunOff,
  input  logic      idleMain,
  input  logic      idleComp,
  input  logic      dtDone,
  output dtStrobe_t strobe,
  output logic      pinMain,
  output logic      pinMainEn,
  output logic      pinComp,
  output logic      pinCompEn
);
  logic refS;
  logic mainEn;
  logic brkHit;
  logic mainRaw;
  logic compRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refS <= 1'b0;
    else       refS <= pwmRef;
  end

  assign strobe.loadDt = (refS != pwmRef);
  assign strobe.stepDt = dtTick;

  assign brkHit = brkEnable & (brkIn == brkPolarity);

  // break clears the main enable without a clock edge
  always_ff @(posedge clk or negedge rstN or posedge brkHit) begin
    if (!rstN)       mainEn <= 1'b0;
    else if (brkHit) mainEn <= 1'b0;
    else if (moeSet) mainEn <= 1'b1;
  end

  assign mainRaw = refS & dtDone;
  assign compRaw = ~refS & dtDone;

  always_comb begin
    pinMain   = 1'b0;
    pinComp   = 1'b0;
    pinMainEn = 1'b0;
    pinCompEn = 1'b0;
    if (mainEn && timerRun) begin
      pinMain   = mainRaw;
      pinComp   = compRaw;
      pinMainEn = 1'b1;
      pinCompEn = 1'b1;
    end else if (mainEn) begin
      pinMainEn = frzRunOn;
      pinCompEn = frzRunOn;
    end else if (frzRunOff) begin
      pinMain   = idleMain;
      pinComp   = idleComp;
      pinMainEn = 1'b1;
      pinCompEn = 1'b1;
    end
  end

  // R10: no clock edge sees the main enable set while a break is asserted
  p_break_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    brkHit |-> !mainEn);

  // R11: with the break disabled the main enable cannot be lost
  p_brk_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    !brkEnable && mainEn |=> mainEn || brkEnable);

  // R12: a set request with no break takes effect next cycle
  p_moe_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    moeSet && !brkHit |=> mainEn || brkHit);

  // R6: the complementary output is already off when the registered reference rises
  p_comp_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refS) && mainEn && timerRun |-> !pinComp);
endmodule

// File: rtl/dtPairStage.sv
module dtPairStage
  import dtPairPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dtTick,
  input  logic              pwmRef,
  input  logic [CODE_W-1:0] dtCode,
  input  logic              timerRun,
  input  logic              moeSet,
  input  logic              brkIn,
  input  logic              brkEnable,
  input  logic              brkPolarity,
  input  logic              frzRunOn,
  input  logic              frzRunOff,
  input  logic              idleMain,
  input  logic              idleComp,
  output logic              pinMain,
  output logic              pinMainEn,
  output logic              pinComp,
  output logic              pinCompEn
);
  dtStrobe_t strobe;
  logic      dtDone;

  dtPairControl uCtrl (
    .clk(clk), .rstN(rstN), .dtTick(dtTick), .pwmRef(pwmRef),
    .timerRun(timerRun), .moeSet(moeSet), .brkIn(brkIn),
    .brkEnable(brkEnable), .brkPolarity(brkPolarity),
    .frzRunOn(frzRunOn), .frzRunOff(frzRunOff),
    .idleMain(idleMain), .idleComp(idleComp), .dtDone(dtDone),
    .strobe(strobe), .pinMain(pinMain), .pinMainEn(pinMainEn),
    .pinComp(pinComp), .pinCompEn(pinCompEn)
  );

  dtPairDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dtCode(dtCode),
    .dtDone(dtDone)
  );
endmodule

// File: tb/sim_dtPairStage.sv
module sim_dtPairStage;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, dtTick, pwmRef, timerRun, moeSet, brkIn, brkEnable, brkPolarity;
  logic frzRunOn, frzRunOff, idleMain, idleComp;
  logic [7:0] dtCode;
  logic pinMain, pinMainEn, pinComp, pinCompEn;

  int nChecks = 0;
  int nFail = 0;

  dtPairStage u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [7:0] c);
    if (c[7] == 1'b0)      return int'(c);
    else if (c[6] == 1'b0) return (64 + int'(c[5:0])) * 2;
    else if (c[5] == 1'b0) return (32 + int'(c[4:0])) * 8;
    else                   return (32 + int'(c[4:0])) * 16;
  endfunction

  function automatic string rangeReq(input logic [7:0] c);
    if (c[7] == 1'b0)      return "R2";
    else if (c[6] == 1'b0) return "R3";
    else if (c[5] == 1'b0) return "R4";
    else                   return "R5";
  endfunction

  // {main, mainEn, comp, compEn} with a settled reference and zero dead-time
  function automatic logic [3:0] expPins(input bit moe, input bit tr, input bit fOn,
                                         input bit fOff, input bit iM, input bit iC,
                                         input bit r);
    if (moe && tr) return {r, 1'b1, ~r, 1'b1};
    else if (moe)  return {1'b0, fOn, 1'b0, fOn};
    else if (fOff) return {iM, 1'b1, iC, 1'b1};
    else           return 4'b0000;
  endfunction

  task automatic pulseMoe();
    @(negedge clk); moeSet = 1'b1;
    @(negedge clk); moeSet = 1'b0;
  endtask

  // one edge of the reference; counts cycles with both outputs low
  task automatic edgeGap(input logic [7:0] code, input bit rise, input bit half,
                         input string req);
    int gap = 0;
    int exp = expLen(code);
    bit first = 1'b1;
    dtTick = 1'b1;
    pwmRef = rise;
    for (int k = 0; k < 2200; k++) begin
      @(negedge clk);
      if (first) begin
        chk((rise ? pinComp : pinMain) == 1'b0, "R6", rise ? pinComp : pinMain, 0);
        first = 1'b0;
      end
      if ((rise ? pinMain : pinComp) == 1'b1) break;
      if (!pinMain && !pinComp) gap++;
      if (half) dtTick = ~dtTick;
    end
    dtTick = 1'b1;
    if (half) chk(gap >= 2*exp-1 && gap <= 2*exp+1, req, gap, 2*exp);
    else      chk(gap == exp, req, gap, exp);
  endtask

  task automatic measure(input logic [7:0] code, input bit half);
    @(negedge clk);
    dtCode = code;
    pwmRef = 1'b0;
    dtTick = 1'b1;
    repeat (1020) @(negedge clk);
    edgeGap(code, 1'b1, half, rangeReq(code));
    repeat (3) @(negedge clk);
    edgeGap(code, 1'b0, half, rangeReq(code));
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] codes [8] = '{8'h00, 8'h35, 8'h7F, 8'h80, 8'hA5, 8'hC3, 8'hE0, 8'hFF};
    void'($urandom(32'd1234));
    rstN = 1'b0; dtTick = 1'b1; pwmRef = 1'b0; dtCode = 8'h00; timerRun = 1'b1;
    moeSet = 1'b0; brkIn = 1'b0; brkEnable = 1'b0; brkPolarity = 1'b1;
    frzRunOn = 1'b0; frzRunOff = 1'b0; idleMain = 1'b0; idleComp = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({pinMain, pinMainEn, pinComp, pinCompEn} == 4'b0000, "R1",
        {pinMain, pinMainEn, pinComp, pinCompEn}, 0);

    // R12: enable the pair
    pulseMoe();
    @(negedge clk);
    chk(pinMainEn && pinCompEn, "R12", {pinMainEn, pinCompEn}, 3);

    // dead-time per range, directed codes
    foreach (codes[i]) measure(codes[i], 1'b0);
    // random codes
    for (int i = 0; i < 6; i++) measure(8'($urandom), 1'b0);
    // half-rate tick
    measure(8'h0A, 1'b1);
    measure(8'hC1, 1'b1);

    // R7: short pulse against a 20-tick dead-time
    @(negedge clk);
    dtCode = 8'd20; pwmRef = 1'b0;
    repeat (30) @(negedge clk);
    begin
      bit sawMain = 1'b0;
      pwmRef = 1'b1;
      repeat (5) begin @(negedge clk); if (pinMain) sawMain = 1'b1; end
      pwmRef = 1'b0;
      repeat (30) begin @(negedge clk); if (pinMain) sawMain = 1'b1; end
      chk(!sawMain, "R7", sawMain, 0);
      chk(pinComp == 1'b1, "R7", pinComp, 1);
    end

    // R10: active-low break mid-cycle, no clock edge in between
    dtCode = 8'h00; pwmRef = 1'b1;
    repeat (3) @(negedge clk);
    chk(pinMain && pinMainEn, "R6", {pinMain, pinMainEn}, 3);
    #3;
    brkPolarity = 1'b0; brkIn = 1'b0; brkEnable = 1'b1;
    #2;
    chk(!pinMainEn && !pinCompEn && !pinMain, "R10", {pinMainEn, pinCompEn}, 0);
    // set request blocked while the break holds
    @(negedge clk); moeSet = 1'b1;
    @(negedge clk); moeSet = 1'b0;
    @(negedge clk);
    chk(!pinMainEn, "R10", pinMainEn, 0);
    // R9: idle levels with main enable clear
    frzRunOff = 1'b1; idleMain = 1'b1; idleComp = 1'b0;
    #1;
    chk({pinMain, pinMainEn, pinComp, pinCompEn} == 4'b1101, "R9",
        {pinMain, pinMainEn, pinComp, pinCompEn}, 4'b1101);
    frzRunOff = 1'b0;
    brkIn = 1'b1;
    pulseMoe();
    @(negedge clk);
    chk(pinMainEn && pinMain, "R12", {pinMainEn, pinMain}, 3);

    // R11: disabled break is ignored
    brkEnable = 1'b0; brkPolarity = 1'b1; brkIn = 1'b1;
    repeat (3) @(negedge clk);
    chk(pinMainEn && pinCompEn && pinMain && !pinComp, "R11",
        {pinMain, pinMainEn, pinComp, pinCompEn}, 4'b1101);
    brkIn = 1'b0;

    // R8: stopped timer with main enable set
    timerRun = 1'b0; frzRunOn = 1'b0;
    @(negedge clk);
    chk({pinMain, pinMainEn, pinComp, pinCompEn} == 4'b0000, "R8",
        {pinMain, pinMainEn, pinComp, pinCompEn}, 0);
    frzRunOn = 1'b1;
    @(negedge clk);
    chk({pinMain, pinMainEn, pinComp, pinCompEn} == 4'b0101, "R8",
        {pinMain, pinMainEn, pinComp, pinCompEn}, 4'b0101);

    // random mix of output-selection settings
    for (int i = 0; i < 24; i++) begin
      bit moe = 1'($urandom);
      bit tr  = 1'($urandom);
      bit fOn = 1'($urandom);
      bit fOff = 1'($urandom);
      bit iM = 1'($urandom);
      bit iC = 1'($urandom);
      bit r  = 1'($urandom);
      logic [3:0] got;
      logic [3:0] exp;
      string req;
      if (moe) pulseMoe();
      else begin
        @(negedge clk); brkEnable = 1'b1; brkPolarity = 1'b1; brkIn = 1'b1;
        @(negedge clk); brkIn = 1'b0; brkEnable = 1'b0;
      end
      timerRun = tr; frzRunOn = fOn; frzRunOff = fOff;
      idleMain = iM; idleComp = iC; pwmRef = r;
      repeat (2) @(negedge clk);
      got = {pinMain, pinMainEn, pinComp, pinCompEn};
      exp = expPins(moe, tr, fOn, fOff, iM, iC, r);
      req = (moe && tr) ? "R6" : (moe ? "R8" : "R9");
      chk(got == exp, req, got, exp);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule